// File: doc/BRIEF.md
# Port Interrupt-on-Change Controller

This block watches an eight-pin input port and raises an interrupt request when an enabled pin changes. Each pin is first brought into the local clock domain. It is then compared against one of two references. In compare-with-default mode the reference is a configured default bit. In compare-with-previous mode the reference is the level the pin had on the previous clock. When the first qualifying event arrives, the block records the pins that caused it in a flag vector. In the same cycle it takes a snapshot of the whole synchronized port into a capture vector.

While the interrupt is pending, the block ignores any further change events. It holds the interrupt until software reads one of two registers, and a configuration bit selects which one. When that bit is set, a read of the capture register clears the interrupt. When it is clear, a read of the pin-level register clears it. The register file and the serial bus sit outside this block. They deliver the read events to it as one-cycle strobes. A pin in compare-with-default mode whose mismatch is still present keeps the interrupt alive across such a read.

The interrupt pin drive supports three modes: active-high push-pull, active-low push-pull and open-drain.

Top module: `ioc_ctrl`

## Requirements
- R1: After reset, the flag vector and the capture vector are all zero and the interrupt is inactive.
- R2: A pin whose enable bit is 0 never raises an interrupt and never shows up in the flag vector.
- R3: When a pin's mode bit is 0, the pin uses compare-with-previous. A single level change on an enabled pin raises exactly one interrupt, and it does not raise the interrupt again after the clear.
- R4: When a pin's mode bit is 1, the pin uses compare-with-default. If the synchronized level differs from its default bit, an interrupt is raised on the next clock edge. No input synchronization delay applies when the default bit itself changes.
- R5: The flag vector has bit i set exactly for each enabled pin i that qualified on the cycle the interrupt was raised. Several pins can be flagged at once.
- R6: On the cycle the interrupt is raised, the capture vector takes the synchronized level of all eight pins. This includes pins that are disabled. The capture vector keeps that value after the interrupt clears.
- R7: While the interrupt is pending, new change events leave the flag vector, the capture vector and the interrupt state unchanged.
- R8: When the clear-select bit is 1, a capture-read strobe clears the interrupt on the next edge. A pin-level read strobe has no effect.
- R9: When the clear-select bit is 0, a pin-level read strobe clears the interrupt on the next edge. A capture-read strobe has no effect.
- R10: If a compare-with-default pin still mismatches when the clear strobe arrives, the interrupt, the flag vector and the capture vector stay as they are.
- R11: Output drive has three modes.
  - With the open-drain bit 0 and the polarity bit 1, the pin is driven high while the interrupt is active and low otherwise.
  - With the open-drain bit 0 and the polarity bit 0, the pin is driven low while active and high otherwise.
  - In both push-pull modes the output enable is always 1.
  - With the open-drain bit 1, the output enable is 1 only while the interrupt is active, and the driven value is 0.
- R12: Each pin passes through a two-flop synchronizer. A pin change applied before clock edge k becomes visible in the flag and capture vectors after edge k+2 and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 8 | Raw port pin levels (asynchronous) |
| irq_en | input | 8 | Per-pin interrupt enable |
| cmp_def | input | 8 | Per-pin mode: 1 compare with default, 0 compare with previous |
| def_val | input | 8 | Per-pin default level for compare-with-default mode |
| clr_on_cap | input | 1 | Clear select: 1 capture read clears, 0 pin-level read clears |
| od_en | input | 1 | 1 selects open-drain interrupt drive |
| pol_high | input | 1 | Push-pull polarity: 1 active high, 0 active low |
| rd_cap | input | 1 | One-cycle strobe: capture register was read |
| rd_lvl | input | 1 | One-cycle strobe: pin-level register was read |
| flags | output | 8 | Pins that caused the pending interrupt |
| capture | output | 8 | Port snapshot taken when the interrupt was raised |
| int_out | output | 1 | Interrupt pin driven value |
| int_oe | output | 1 | Interrupt pin output enable |

## Verification
The assertions check four things on every cycle.
- An idle block holds an empty flag vector and a pending one holds a non-empty flag vector.
- A flagged pin was enabled on the cycle it was recorded.
- The flags and capture hold still while pending unless a valid clear is taken, and a valid clear always drops the interrupt.
- The open-drain and push-pull drive rules are never broken.

Only the bench scenarios can show the rest.
- The two-edge synchronizer latency.
- That one change fires exactly once and does not return after a clear.
- That the two clear sources are selected correctly.
- That a persisting default mismatch survives a read.
- That the captured port image matches the stimulus.

// File: rtl/ioc_pkg.sv
package ioc_pkg;

  localparam int unsigned PORT_W = 8;

  // Per-pin qualifying event: enabled and differs from its chosen reference.
  function automatic logic [PORT_W-1:0] ioc_hit(
    input logic [PORT_W-1:0] en,
    input logic [PORT_W-1:0] mode_def,
    input logic [PORT_W-1:0] defv,
    input logic [PORT_W-1:0] cur,
    input logic [PORT_W-1:0] prev
  );
    logic [PORT_W-1:0] ref_v;
    ref_v = (mode_def & defv) | (~mode_def & prev);
    return en & (cur ^ ref_v);
  endfunction

  // Pins in default mode that still mismatch: these block a clear.
  function automatic logic [PORT_W-1:0] ioc_hold(
    input logic [PORT_W-1:0] en,
    input logic [PORT_W-1:0] mode_def,
    input logic [PORT_W-1:0] defv,
    input logic [PORT_W-1:0] cur
  );
    return en & mode_def & (cur ^ defv);
  endfunction

  typedef struct packed {
    logic val;
    logic oe;
  } pin_drive_t;

  function automatic pin_drive_t ioc_drive(
    input logic active,
    input logic open_drain,
    input logic act_high
  );
    pin_drive_t d;
    if (open_drain) begin
      d.val = 1'b0;
      d.oe  = active;
    end else begin
      d.val = act_high ? active : ~active;
      d.oe  = 1'b1;
    end
    return d;
  endfunction

endpackage

// File: rtl/ioc_sync.sv
module ioc_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/ioc_detect.sv
module ioc_detect
  import ioc_pkg::*;
#(
  parameter int unsigned WIDTH = PORT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] irq_en,
  input  logic [WIDTH-1:0] cmp_def,
  input  logic [WIDTH-1:0] def_val,
  output logic [WIDTH-1:0] hit,
  output logic             hold_any
);

  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] hold_vec;

  // Previous sample advances every cycle so a change is seen once.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= cur;
  end

  assign hit      = ioc_hit(irq_en, cmp_def, def_val, cur, prev_q);
  assign hold_vec = ioc_hold(irq_en, cmp_def, def_val, cur);
  assign hold_any = |hold_vec;

  // R2: no event on a disabled pin
  assert_hit_enabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit & ~irq_en) == '0);

  // R10: a held pin is always also a qualifying pin
  assert_hold_in_hit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_vec & ~hit) == '0);

endmodule

// File: rtl/ioc_capture.sv
module ioc_capture #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] hit,
  input  logic [WIDTH-1:0] irq_en,
  input  logic             hold_any,
  input  logic             clr_req,
  output logic [WIDTH-1:0] flags,
  output logic [WIDTH-1:0] capture,
  output logic             pending
);

  logic fire_ev;
  logic clear_ev;

  assign fire_ev  = !pending && (|hit);
  assign clear_ev = pending && clr_req && !hold_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      flags   <= '0;
      capture <= '0;
    end else if (fire_ev) begin
      pending <= 1'b1;
      flags   <= hit;
      capture <= cur;
    end else if (clear_ev) begin
      pending <= 1'b0;
      flags   <= '0;
    end
  end

  // R1 / R5: flags empty exactly when idle
  assert_idle_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !pending |-> flags == '0);
  assert_pending_flagged_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> flags != '0);

  // R2: recorded pins were enabled when recorded
  assert_flags_enabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending) |-> (flags & ~$past(irq_en)) == '0);

  // R7 / R10: state frozen while pending unless a valid clear occurs
  assert_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !(clr_req && !hold_any)) |=>
      (pending && $stable(flags) && $stable(capture)));

  // R8 / R9: a valid clear drops the interrupt
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && clr_req && !hold_any) |=> !pending);

endmodule

// File: rtl/ioc_drive.sv
module ioc_drive
  import ioc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic od_en,
  input  logic pol_high,
  output logic int_out,
  output logic int_oe
);

  pin_drive_t drv;

  assign drv     = ioc_drive(active, od_en, pol_high);
  assign int_out = drv.val;
  assign int_oe  = drv.oe;

  // R11: open-drain only pulls low, and only while active
  assert_od_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    od_en |-> (!int_out && (int_oe == active)));

  // R11: push-pull always drives
  assert_pp_drive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !od_en |-> int_oe);

endmodule

// File: rtl/ioc_ctrl.sv
module ioc_ctrl
  import ioc_pkg::*;
#(
  parameter int unsigned WIDTH       = PORT_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_in,
  input  logic [WIDTH-1:0] irq_en,
  input  logic [WIDTH-1:0] cmp_def,
  input  logic [WIDTH-1:0] def_val,
  input  logic             clr_on_cap,
  input  logic             od_en,
  input  logic             pol_high,
  input  logic             rd_cap,
  input  logic             rd_lvl,
  output logic [WIDTH-1:0] flags,
  output logic [WIDTH-1:0] capture,
  output logic             int_out,
  output logic             int_oe
);

  logic [WIDTH-1:0] pin_sync;
  logic [WIDTH-1:0] hit;
  logic             hold_any;
  logic             clr_req;
  logic             pending;

  // Selected clear source
  assign clr_req = clr_on_cap ? rd_cap : rd_lvl;

  ioc_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (pin_in),
    .q_sync  (pin_sync)
  );

  ioc_detect #(.WIDTH(WIDTH)) u_detect (
    .clk      (clk),
    .rst_n    (rst_n),
    .cur      (pin_sync),
    .irq_en   (irq_en),
    .cmp_def  (cmp_def),
    .def_val  (def_val),
    .hit      (hit),
    .hold_any (hold_any)
  );

  ioc_capture #(.WIDTH(WIDTH)) u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .cur      (pin_sync),
    .hit      (hit),
    .irq_en   (irq_en),
    .hold_any (hold_any),
    .clr_req  (clr_req),
    .flags    (flags),
    .capture  (capture),
    .pending  (pending)
  );

  ioc_drive u_drive (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (pending),
    .od_en    (od_en),
    .pol_high (pol_high),
    .int_out  (int_out),
    .int_oe   (int_oe)
  );

  // R6: snapshot equals synchronized port on the raising edge
  assert_snapshot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending) |-> capture == $past(pin_sync));

  // R8 / R9: the unselected read never clears
  assert_wrong_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !clr_req && (hit == '0)) |=> pending);

endmodule

// File: tb/ioc_ctrl_tb.sv
`timescale 1ns/100ps
module ioc_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pin_in = '0, irq_en = '0, cmp_def = '0, def_val = '0;
  logic       clr_on_cap = 1'b0, od_en = 1'b0, pol_high = 1'b0;
  logic       rd_cap = 1'b0, rd_lvl = 1'b0;
  logic [7:0] flags, capture;
  logic       int_out, int_oe;

  always #2.5 clk = ~clk;

  ioc_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .irq_en(irq_en),
    .cmp_def(cmp_def), .def_val(def_val), .clr_on_cap(clr_on_cap),
    .od_en(od_en), .pol_high(pol_high), .rd_cap(rd_cap), .rd_lvl(rd_lvl),
    .flags(flags), .capture(capture), .int_out(int_out), .int_oe(int_oe)
  );

  typedef struct {
    string      tag;
    logic [7:0] fl;
    logic [7:0] cap;
    logic       io;
    logic       oe;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done   = 1'b0;

  // Bench's own view of the pin drive rules
  function automatic logic [1:0] exp_drive(input logic act, input logic od, input logic ph);
    if (od) return {1'b0, act};
    return {(ph ? act : !act), 1'b1};
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_st(input string tag, input logic [7:0] fl,
                           input logic [7:0] cap, input logic act);
    exp_t e;
    logic [1:0] d;
    d = exp_drive(act, od_en, pol_high);
    e.tag = tag; e.fl = fl; e.cap = cap; e.io = d[1]; e.oe = d[0];
    q.push_back(e);
  endtask

  task automatic pulse_cap();
    rd_cap = 1'b1; step(1); rd_cap = 1'b0;
  endtask

  task automatic pulse_lvl();
    rd_lvl = 1'b1; step(1); rd_lvl = 1'b0;
  endtask

  // Monitor: pop expectations and compare shortly after the falling edge
  initial begin
    forever begin
      @(negedge clk);
      #0.2;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (flags !== e.fl || capture !== e.cap || int_out !== e.io || int_oe !== e.oe) begin
          errors++;
          $display("FAIL %s: flags=%h cap=%h out=%b oe=%b expected flags=%h cap=%h out=%b oe=%b",
                   e.tag, flags, capture, int_out, int_oe, e.fl, e.cap, e.io, e.oe);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1: reset state, active-low push-pull idle drives high
    expect_st("R1 reset state", 8'h00, 8'h00, 1'b0);
    step(1);

    // R11: drive modes while idle
    pol_high = 1'b1; expect_st("R11 idle active-high", 8'h00, 8'h00, 1'b0); step(1);
    od_en = 1'b1;    expect_st("R11 idle open-drain", 8'h00, 8'h00, 1'b0); step(1);
    od_en = 1'b0;

    // R2: disabled pin change is ignored
    pin_in = 8'h01;
    step(5);
    expect_st("R2 disabled pin ignored", 8'h00, 8'h00, 1'b0);
    step(1);

    // R12 / R3 / R6: previous-value mode, capture clear source
    irq_en = 8'hFF; cmp_def = 8'h00; clr_on_cap = 1'b1;
    step(2);
    pin_in = 8'h05;
    step(2);
    expect_st("R12 not visible after two edges", 8'h00, 8'h00, 1'b0);
    step(1);
    expect_st("R12 R3 R6 event after third edge", 8'h04, 8'h05, 1'b1);
    step(1);

    // R7: further change while pending is ignored
    pin_in = 8'h85;
    step(5);
    expect_st("R7 pending suppresses new event", 8'h04, 8'h05, 1'b1);
    step(1);

    // R8: pin-level read does not clear when capture is selected
    pulse_lvl();
    expect_st("R8 level read no clear", 8'h04, 8'h05, 1'b1);
    step(1);
    pulse_cap();
    expect_st("R8 capture read clears", 8'h00, 8'h05, 1'b0);
    step(4);
    expect_st("R3 no re-trigger after clear", 8'h00, 8'h05, 1'b0);
    step(1);

    // R5 / R2: many pins change, only enabled ones flagged
    irq_en = 8'h0F;
    step(1);
    pin_in = 8'h7A;
    step(3);
    expect_st("R5 R2 multi-pin flags", 8'h0F, 8'h7A, 1'b1);
    step(1);

    // R9: level read selected
    clr_on_cap = 1'b0;
    step(1);
    pulse_cap();
    expect_st("R9 capture read no clear", 8'h0F, 8'h7A, 1'b1);
    step(1);
    pulse_lvl();
    expect_st("R9 level read clears", 8'h00, 8'h7A, 1'b0);
    step(2);

    // R4: default mode, matching default gives nothing
    irq_en = 8'h10; cmp_def = 8'h10; def_val = 8'h10;
    step(2);
    expect_st("R4 default match no event", 8'h00, 8'h7A, 1'b0);
    step(1);
    def_val = 8'h00;
    step(1);
    expect_st("R4 default mismatch raises", 8'h10, 8'h7A, 1'b1);
    step(1);

    // R11: drive modes while active
    pol_high = 1'b0; expect_st("R11 active-low asserted", 8'h10, 8'h7A, 1'b1); step(1);
    od_en = 1'b1;    expect_st("R11 open-drain asserted", 8'h10, 8'h7A, 1'b1); step(1);
    od_en = 1'b0; pol_high = 1'b1;

    // R10: read while mismatch persists keeps interrupt
    pulse_lvl();
    expect_st("R10 read with mismatch stays", 8'h10, 8'h7A, 1'b1);
    step(1);
    pin_in = 8'h6A;
    step(4);
    expect_st("R7 pending after pin fix", 8'h10, 8'h7A, 1'b1);
    step(1);
    pulse_lvl();
    expect_st("R10 read after mismatch gone clears", 8'h00, 8'h7A, 1'b0);
    step(4);
    expect_st("R4 no event once matched", 8'h00, 8'h7A, 1'b0);
    step(2);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule